// File: doc/BRIEF.md
# Time-aware transmit gate scheduler

This block sits on one transmit port and opens or closes the eight priority gates seen by the queue arbiter, following a schedule that software loads into a command store. Each command pairs a gate-allow mask with a budget of transmitted units. The block presents the mask of the current command until the port has sent that many units, then moves on to the next command. A cycle-start pulse from an external time base restarts the list at entry 0 of the active bank.

The command store has two banks. Software fills the idle bank and then flips a bank-select control bit. The sequencer adopts the new bank only on a cycle-start pulse, so a schedule is never changed partway through a cycle. A status word reports the current gate mask, two sticky error flags and the bank actually in use. Budgets are counted in bytes at gigabit speed and in nibbles at 10/100 speeds. The block receives one strobe per transmitted byte and scales it by the link-speed select.

Top module: `tx_gate_sched`

## Requirements
- R1: A command word carries the unit budget in bits 21:8 and the gate-allow mask in bits 7:0, with one bit per priority. While a command is current, `gate_mask` equals its mask.
- R2: With `low_speed`=0 each `tx_unit` strobe counts 1 unit. A command with budget N hands over to the next entry right after its Nth strobe.
- R3: With `low_speed`=1 each `tx_unit` strobe counts 2 units (nibbles). A command with budget N hands over after ceil(N/2) strobes.
- R4: A command with budget 0 holds its mask until the next cycle start. Strobes do not move the walk past it.
- R5: A `cycle_start` pulse while enabled restarts the walk at entry 0 of the active bank. The new mask appears in the cycle after the pulse.
- R6: A change of the bank-select bit takes effect only at an enabled `cycle_start`. Status bit 10 reports the bank in use, and a pulse while disabled does not swap banks.
- R7: A `cycle_start` that arrives while the walk is still on a command with a nonzero budget sets the sticky count-error flag (status bit 8) and still restarts the walk.
- R8: When the budget of the last entry of a bank runs out, the sticky address-error flag (status bit 9) is set and the last mask is held until the next cycle start.
- R9: Scheduling runs only when both the global enable and the port enable are set. Otherwise `gate_mask` is all ones. After enabling, the gates stay all ones until the first `cycle_start`.
- R10: Control write encoding: bit 0 is the global enable, bit 1 the port enable, bit 2 the bank select, and bit 3 written as 1 clears both error flags. After reset all are 0.
- R11: Status bits 7:0 always equal `gate_mask`. After reset the status word is 11'h0FF.
- R12: RAM write address: the top bit picks the bank and the low bits pick the entry within the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write data (enables, bank select, error clear) |
| ram_we | input | 1 | Command store write strobe |
| ram_addr | input | $clog2(ENTRIES)+1 | Bank bit on top, entry index below |
| ram_wdata | input | 22 | Command word: budget 21:8, mask 7:0 |
| cycle_start | input | 1 | Cycle-start pulse from the time base |
| tx_unit | input | 1 | One pulse per transmitted byte |
| low_speed | input | 1 | 1 = 10/100 link (nibble units), 0 = gigabit (byte units) |
| gate_mask | output | 8 | Per-priority transmit allow to the arbiter |
| status | output | 11 | Bit 10 active bank, 9 address error, 8 count error, 7:0 gate mask |

## Verification
The bench builds the block with ENTRIES=8 instead of 64. This makes the address-error path reachable by walking a full bank with eight single-unit commands. Both banks are loaded so that a bank swap, a completed list ending on a zero-budget command, a list cut short by an early pulse, and a list that runs off the end all occur in one short run. Both speed settings are exercised with an odd budget, which checks how the nibble count rounds up.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

  localparam int CNT_W  = 14;
  localparam int MASK_W = 8;
  localparam int CMD_W  = CNT_W + MASK_W;
  localparam int STAT_W = MASK_W + 3;

  // control write bit positions
  localparam int CTL_GLB  = 0;
  localparam int CTL_PORT = 1;
  localparam int CTL_BANK = 2;
  localparam int CTL_CLR  = 3;
  localparam int CTL_W    = 4;

  // status bit positions above the mask
  localparam int ST_CERR = MASK_W;
  localparam int ST_AERR = MASK_W + 1;
  localparam int ST_BANK = MASK_W + 2;

  // budget in the upper bits, mask in the lower bits
  typedef struct packed {
    logic [CNT_W-1:0]  budget;
    logic [MASK_W-1:0] allow;
  } gate_cmd_t;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_RUN  = 2'd1,
    WALK_HALT = 2'd2
  } walk_st_e;

endpackage

// File: rtl/tgs_ctl_reg.sv
module tgs_ctl_reg
  import tgs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic             run_en,
  output logic             bank_sel,
  output logic             err_clr
);

  logic glb_q, port_q, bank_q;
  logic glb_d, port_d, bank_d;

  always_comb begin
    glb_d  = glb_q;
    port_d = port_q;
    bank_d = bank_q;
    if (we) begin
      glb_d  = wdata[CTL_GLB];
      port_d = wdata[CTL_PORT];
      bank_d = wdata[CTL_BANK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q  <= 1'b0;
      port_q <= 1'b0;
      bank_q <= 1'b0;
    end else if (we) begin
      glb_q  <= glb_d;
      port_q <= port_d;
      bank_q <= bank_d;
    end
  end

  assign run_en   = glb_q & port_q;
  assign bank_sel = bank_q;
  assign err_clr  = we & wdata[CTL_CLR];

  a_r10_enable_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (run_en == ($past(wdata[CTL_GLB]) & $past(wdata[CTL_PORT]))));

endmodule

// File: rtl/tgs_cmd_ram.sv
module tgs_cmd_ram
  import tgs_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [IDX_W-1:0] wr_idx,
  input  gate_cmd_t        wr_cmd,
  input  logic             rd_bank,
  input  logic [IDX_W-1:0] rd_idx,
  output gate_cmd_t        rd_cmd
);

  localparam int BANKS = 2;

  gate_cmd_t bank_rd [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    gate_cmd_t mem [ENTRIES];
    logic      bank_we;

    assign bank_we = wr_en && (wr_bank == b[0]);

    always_ff @(posedge clk) begin
      if (bank_we) begin
        mem[wr_idx] <= wr_cmd;
      end
    end

    assign bank_rd[b] = mem[rd_idx];
  end

  assign rd_cmd = rd_bank ? bank_rd[1] : bank_rd[0];

endmodule

// File: rtl/tgs_walker.sv
module tgs_walker
  import tgs_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int USED_W = CNT_W + 1,
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cycle_start,
  input  logic             tx_unit,
  input  logic             low_speed,
  input  logic             bank_sel,
  input  logic             err_clr,
  input  gate_cmd_t        cur_cmd,
  output logic             act_bank,
  output logic [IDX_W-1:0] ptr,
  output logic             gate_live,
  output logic             cnt_err,
  output logic             addr_err
);

  walk_st_e         st_q, st_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [USED_W-1:0] used_q, used_d;
  logic             bank_q, bank_d;
  logic             cerr_q, cerr_d;
  logic             aerr_q, aerr_d;

  logic [USED_W-1:0] step;
  logic [USED_W-1:0] sum;
  logic              zero_cmd;
  logic              cmd_done;
  logic              list_over;
  logic              restart;

  assign step      = low_speed ? USED_W'(2) : USED_W'(1);
  assign sum       = used_q + step;
  assign zero_cmd  = (cur_cmd.budget == '0);
  assign cmd_done  = !zero_cmd && (sum >= {1'b0, cur_cmd.budget});
  assign list_over = (st_q == WALK_HALT) || zero_cmd;
  assign restart   = run_en && cycle_start;

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    used_d = used_q;
    bank_d = bank_q;
    cerr_d = cerr_q & ~err_clr;
    aerr_d = aerr_q & ~err_clr;
    if (!run_en) begin
      st_d   = WALK_IDLE;
      ptr_d  = '0;
      used_d = '0;
    end else if (cycle_start) begin
      if (st_q == WALK_RUN && !list_over) begin
        cerr_d = 1'b1;
      end
      st_d   = WALK_RUN;
      ptr_d  = '0;
      used_d = '0;
      bank_d = bank_sel;
    end else if (st_q == WALK_RUN && tx_unit && !zero_cmd) begin
      if (cmd_done) begin
        used_d = '0;
        if (ptr_q == LAST) begin
          st_d   = WALK_HALT;
          aerr_d = 1'b1;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end else begin
        used_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WALK_IDLE;
      ptr_q  <= '0;
      used_q <= '0;
      bank_q <= 1'b0;
      cerr_q <= 1'b0;
      aerr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      used_q <= used_d;
      cerr_q <= cerr_d;
      aerr_q <= aerr_d;
      if (restart) begin
        bank_q <= bank_d;
      end
    end
  end

  assign act_bank  = bank_q;
  assign ptr       = ptr_q;
  assign gate_live = (st_q != WALK_IDLE);
  assign cnt_err   = cerr_q;
  assign addr_err  = aerr_q;

  a_r5_restart_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ptr == '0) && gate_live);

  a_r6_bank_from_select: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (act_bank == $past(bank_sel)));

  a_r6_bank_swap_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(act_bank));

  a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !gate_live);

  a_r7_count_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err && !err_clr |=> cnt_err);

  a_r8_halt_holds_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WALK_HALT) && run_en && !cycle_start |=> (st_q == WALK_HALT) && $stable(ptr));

  a_r4_zero_budget_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WALK_RUN) && zero_cmd && run_en && !cycle_start |=> $stable(ptr));

endmodule

// File: rtl/tx_gate_sched.sv
module tx_gate_sched
  import tgs_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              ram_we,
  input  logic [IDX_W:0]    ram_addr,
  input  logic [CMD_W-1:0]  ram_wdata,
  input  logic              cycle_start,
  input  logic              tx_unit,
  input  logic              low_speed,
  output logic [MASK_W-1:0] gate_mask,
  output logic [STAT_W-1:0] status
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync[1];

  logic             run_en, bank_sel, err_clr;
  logic             act_bank, gate_live, cnt_err, addr_err;
  logic [IDX_W-1:0] ptr;
  gate_cmd_t        cur_cmd;

  tgs_ctl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_ni),
    .we       (ctl_we),
    .wdata    (ctl_wdata),
    .run_en   (run_en),
    .bank_sel (bank_sel),
    .err_clr  (err_clr)
  );

  tgs_cmd_ram #(.ENTRIES(ENTRIES)) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_bank (ram_addr[IDX_W]),
    .wr_idx  (ram_addr[IDX_W-1:0]),
    .wr_cmd  (gate_cmd_t'(ram_wdata)),
    .rd_bank (act_bank),
    .rd_idx  (ptr),
    .rd_cmd  (cur_cmd)
  );

  tgs_walker #(.ENTRIES(ENTRIES)) u_walk (
    .clk         (clk),
    .rst_n       (rst_ni),
    .run_en      (run_en),
    .cycle_start (cycle_start),
    .tx_unit     (tx_unit),
    .low_speed   (low_speed),
    .bank_sel    (bank_sel),
    .err_clr     (err_clr),
    .cur_cmd     (cur_cmd),
    .act_bank    (act_bank),
    .ptr         (ptr),
    .gate_live   (gate_live),
    .cnt_err     (cnt_err),
    .addr_err    (addr_err)
  );

  assign gate_mask = gate_live ? cur_cmd.allow : '1;
  assign status    = {act_bank, addr_err, cnt_err, gate_mask};

  a_r9_open_when_disabled: assert property (@(posedge clk) disable iff (!rst_ni)
    !run_en |=> (gate_mask == '1));

endmodule

// File: tb/tx_gate_sched_bench.sv
module tx_gate_sched_bench;

  localparam int ENTRIES = 8;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [3:0]  ctl_wdata;
  logic        ram_we;
  logic [IDX_W:0] ram_addr;
  logic [21:0] ram_wdata;
  logic        cycle_start;
  logic        tx_unit;
  logic        low_speed;
  logic [7:0]  gate_mask;
  logic [10:0] status;

  always #2 clk = ~clk;

  tx_gate_sched #(.ENTRIES(ENTRIES)) u_tx_gate_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_wdata   (ctl_wdata),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata),
    .cycle_start (cycle_start),
    .tx_unit     (tx_unit),
    .low_speed   (low_speed),
    .gate_mask   (gate_mask),
    .status      (status)
  );

  typedef struct {
    logic [7:0]  g;
    logic [10:0] s;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (gate_mask !== e.g || status !== e.s) begin
        n_fail++;
        $display("FAIL %s: gate=%h status=%h expected gate=%h status=%h",
                 e.tag, gate_mask, status, e.g, e.s);
      end
    end
  end

  function automatic logic [10:0] stat(input bit bank, input bit aerr,
                                       input bit cerr, input logic [7:0] g);
    return {bank, aerr, cerr, g};
  endfunction

  task automatic expect_out(input logic [7:0] g, input logic [10:0] s, input string tag);
    exp_t e;
    e.g = g; e.s = s; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    edge1();
    ctl_we = 1'b0;
  endtask

  task automatic wr_cmd(input bit bank, input int idx, input int budget, input logic [7:0] m);
    ram_we = 1'b1;
    ram_addr = {bank, IDX_W'(idx)};
    ram_wdata = {14'(budget), m};
    edge1();
    ram_we = 1'b0;
  endtask

  task automatic pulse_start();
    cycle_start = 1'b1;
    edge1();
    cycle_start = 1'b0;
  endtask

  task automatic strobe(input int n);
    tx_unit = 1'b1;
    repeat (n) edge1();
    tx_unit = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; ram_we = 1'b0;
    ram_addr = '0; ram_wdata = '0; cycle_start = 1'b0; tx_unit = 1'b0;
    low_speed = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) edge1();

    // R11 R10: reset state
    expect_out(8'hFF, 11'h0FF, "R11 reset status");

    // R12: bank 0 and bank 1 loading through the bank bit of the address
    wr_cmd(0, 0, 3, 8'h01);
    wr_cmd(0, 1, 2, 8'h02);
    wr_cmd(0, 2, 0, 8'hF0);
    for (int i = 0; i < ENTRIES; i++) wr_cmd(1, i, 1, 8'h20 + 8'(i));
    wr_cmd(1, 0, 1, 8'h11);

    // R9: enabled but no cycle start yet
    wr_ctl(4'b0011);
    edge1();
    expect_out(8'hFF, stat(0, 0, 0, 8'hFF), "R9 ones before first start");

    // R5 R1 R12: start on bank 0
    pulse_start();
    expect_out(8'h01, stat(0, 0, 0, 8'h01), "R5 entry 0 after start");
    strobe(2);
    expect_out(8'h01, stat(0, 0, 0, 8'h01), "R2 budget not yet spent");
    strobe(1);
    expect_out(8'h02, stat(0, 0, 0, 8'h02), "R2 advance after 3 bytes");
    strobe(2);
    expect_out(8'hF0, stat(0, 0, 0, 8'hF0), "R4 zero budget entry reached");
    strobe(5);
    expect_out(8'hF0, stat(0, 0, 0, 8'hF0), "R4 zero budget holds");

    // R6: select bank 1; no change until start
    wr_ctl(4'b0111);
    edge1();
    expect_out(8'hF0, stat(0, 0, 0, 8'hF0), "R6 no swap mid cycle");
    pulse_start();
    expect_out(8'h11, stat(1, 0, 0, 8'h11), "R6 swap at start, R7 no error after finished list");

    // R8: run off the end of bank 1
    strobe(7);
    expect_out(8'h27, stat(1, 0, 0, 8'h27), "R8 last entry reached");
    strobe(1);
    expect_out(8'h27, stat(1, 1, 0, 8'h27), "R8 address error set");
    strobe(2);
    expect_out(8'h27, stat(1, 1, 0, 8'h27), "R8 last mask held");

    // R10: clear errors, select bank 0 again
    wr_ctl(4'b1011);
    expect_out(8'h27, stat(1, 0, 0, 8'h27), "R10 errors cleared");

    // R3: nibble counting on bank 0
    wr_cmd(0, 0, 5, 8'h04);
    low_speed = 1'b1;
    pulse_start();
    expect_out(8'h04, stat(0, 0, 0, 8'h04), "R3 start bank 0");
    strobe(2);
    expect_out(8'h04, stat(0, 0, 0, 8'h04), "R3 four nibbles of five");
    strobe(1);
    expect_out(8'h02, stat(0, 0, 0, 8'h02), "R3 odd budget rounds up");
    strobe(1);
    expect_out(8'hF0, stat(0, 0, 0, 8'hF0), "R3 two nibbles in one byte");

    // R7: early start
    pulse_start();
    expect_out(8'h04, stat(0, 0, 0, 8'h04), "R7 restart without error");
    strobe(1);
    pulse_start();
    expect_out(8'h04, stat(0, 0, 1, 8'h04), "R7 count error on early start");
    strobe(2);
    expect_out(8'h04, stat(0, 0, 1, 8'h04), "R7 walk restarted from zero");

    // R9 R6: disable port, pulse must not swap
    wr_ctl(4'b0101);
    edge1();
    expect_out(8'hFF, stat(0, 0, 1, 8'hFF), "R9 disabled gates open");
    pulse_start();
    expect_out(8'hFF, stat(0, 0, 1, 8'hFF), "R6 no swap while disabled");

    // R9: re-enable on bank 0
    wr_ctl(4'b0011);
    edge1();
    expect_out(8'hFF, stat(0, 0, 1, 8'hFF), "R9 ones until start after enable");
    low_speed = 1'b0;
    pulse_start();
    expect_out(8'h04, stat(0, 0, 1, 8'h04), "R9 schedule resumes");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule